// File: doc/BRIEF.md
# Quadrature Position Counter with Snapshot Register

This block tracks the position of one motion axis from an incremental encoder. The two quadrature channels and the index channel arrive asynchronously and pass through a synchronizer. Every edge on either channel moves a 24-bit two's-complement position counter by one count. The direction of the move comes from the phase order of the two channels.

Software never reads the live counter. It reads a snapshot register, which is offered as three bytes. The bytes stay consistent with each other for as long as the snapshot is not updated. A mode input chooses what updates the snapshot. In timed mode, a strobe shared by all axes updates it; that strobe comes from a periodic timer or a software command. In index mode, the synchronized rising edge of the index channel updates it and also sets a sticky flag. The flag clears when software reports that it has read it.

A level-held load input presets the live counter to a 24-bit value. The host keeps this input high for at least 20 clocks.

Top module: `qenc_axis`

## Requirements
- R1: After reset the snapshot bytes and the index flag are all zero. The live counter also starts at zero.
- R2: Take the channel pair as {A,B}. The sequence 00→10→11→01→00 has A leading B, and each transition in it adds one to the counter.
- R3: The reverse sequence 00→01→11→10→00 subtracts one from the counter on each transition.
- R4: A change of both channels between two consecutive synchronized samples leaves the counter unchanged.
- R5: The counter wraps modulo 2^24. One count up from 0xFFFFFF gives 0x000000, and one count down from 0x000000 gives 0xFFFFFF.
- R6: The outputs show only the snapshot. The low byte carries bits 7:0, the middle byte bits 15:8 and the high byte bits 23:16. Counter movement does not change them until a capture occurs.
- R7: With index mode low, every clock in which the strobe is high copies the counter into the snapshot. Index edges capture nothing and leave the flag unchanged.
- R8: With index mode high, a synchronized rising edge of the index channel copies the counter into the snapshot and sets the flag. The strobe is ignored in this mode.
- R9: The flag stays set until a clock in which the read-clear input is high. If a new index capture happens in that same clock, the flag stays set.
- R10: In every clock in which load is high, the counter takes the preload value. Any count step from that same clock is discarded.
- R11: The counter registers a channel edge three clocks after the raw input changes: two synchronizer stages, then the counter register. A capture stores the counter value held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| quad_a_in | input | 1 | Raw quadrature channel A |
| quad_b_in | input | 1 | Raw quadrature channel B |
| index_in | input | 1 | Raw index channel |
| snap_strobe_i | input | 1 | Shared capture strobe used in timed mode |
| index_mode_i | input | 1 | 1: capture on index edge; 0: capture on strobe |
| load_pos_i | input | 1 | Level-held counter preset |
| preload_i | input | 24 | Preset value |
| sense_rd_i | input | 1 | Read of the index flag; clears it |
| snap_lo_o | output | 8 | Snapshot bits 7:0 |
| snap_mid_o | output | 8 | Snapshot bits 15:8 |
| snap_hi_o | output | 8 | Snapshot bits 23:16 |
| index_flag_o | output | 1 | Sticky index-capture flag |

## Verification
The bound checker watches several properties on every clock:
- the live counter never moves by more than one count outside a load;
- a load always wins over a count step;
- the snapshot stays frozen unless the selected capture source fired;
- the flag rises only in index mode and falls only after a read.

Other behaviour shows up only in the bench scenarios:
- the direction of counting;
- rejection of double-channel changes;
- wrap at both ends of the range;
- the set-wins case of the flag;
- the three-clock edge latency.

The bench's reference model checks these against the snapshot and flag on every clock.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

   typedef enum logic [1:0] {
      MOVE_NONE = 2'd0,
      MOVE_FWD  = 2'd1,
      MOVE_REV  = 2'd2
   } move_e;

   // Position of a channel pair within the Gray cycle 00,10,11,01 ({A,B})
   function automatic logic [1:0] phase_of(input logic [1:0] ab);
      return {ab[0], ab[1] ^ ab[0]};
   endfunction

   // A phase difference of +1 is forward and -1 is reverse; 0 or 2 makes no move
   function automatic move_e classify(input logic [1:0] prev_ab, input logic [1:0] cur_ab);
      logic [1:0] d;
      d = phase_of(cur_ab) - phase_of(prev_ab);
      case (d)
         2'd1:    return MOVE_FWD;
         2'd3:    return MOVE_REV;
         default: return MOVE_NONE;
      endcase
   endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= '0;
      else        pipe[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= '0;
         else        pipe[s] <= pipe[s-1];
      end
   end

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
   import qenc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ab_i,
   output move_e      move_o
);
   logic [1:0] ab_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ab_prev <= 2'b00;
      else        ab_prev <= ab_i;
   end

   assign move_o = classify(ab_prev, ab_i);
endmodule

// File: rtl/qenc_count.sv
module qenc_count
   import qenc_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] preload_i,
   input  move_e            move_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] UNIT = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (load_i) begin
         cnt_o <= preload_i;
      end else begin
         case (move_i)
            MOVE_FWD: cnt_o <= cnt_o + UNIT;
            MOVE_REV: cnt_o <= cnt_o - UNIT;
            default:  cnt_o <= cnt_o;
         endcase
      end
   end
endmodule

// File: rtl/qenc_snap.sv
module qenc_snap #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_idx_i,
   input  logic             strobe_i,
   input  logic             idx_i,
   input  logic             rd_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] snap_o,
   output logic             flag_o
);
   logic idx_prev;
   logic idx_rise;
   logic take;

   assign idx_rise = idx_i & ~idx_prev;
   assign take     = mode_idx_i ? idx_rise : strobe_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_prev <= 1'b0;
         snap_o   <= '0;
         flag_o   <= 1'b0;
      end else begin
         idx_prev <= idx_i;
         if (take) snap_o <= cnt_i;
         if (mode_idx_i && idx_rise) flag_o <= 1'b1;
         else if (rd_i)              flag_o <= 1'b0;
      end
   end
endmodule

// File: rtl/qenc_axis.sv
module qenc_axis
   import qenc_pkg::*;
#(
   parameter int CNT_W       = 24,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              quad_a_in,
   input  logic              quad_b_in,
   input  logic              index_in,
   input  logic              snap_strobe_i,
   input  logic              index_mode_i,
   input  logic              load_pos_i,
   input  logic [CNT_W-1:0]  preload_i,
   input  logic              sense_rd_i,
   output logic [BYTE_W-1:0] snap_lo_o,
   output logic [BYTE_W-1:0] snap_mid_o,
   output logic [BYTE_W-1:0] snap_hi_o,
   output logic              index_flag_o
);
   localparam int NUM_BYTES = CNT_W / BYTE_W;
   localparam int SYNC_W    = 3;

   if (NUM_BYTES != 3 || CNT_W != NUM_BYTES * BYTE_W) begin : g_bad_width
      $error("qenc_axis: CNT_W must be exactly three BYTE_W bytes");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("qenc_axis: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_W-1:0] raw_in;
   logic [SYNC_W-1:0] sync_q;
   move_e             move;
   logic [CNT_W-1:0]  live_cnt;
   logic [CNT_W-1:0]  snap_q;

   assign raw_in = {index_in, quad_a_in, quad_b_in};

   qenc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in),
      .dout (sync_q)
   );

   qenc_decode u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .ab_i  (sync_q[1:0]),
      .move_o(move)
   );

   qenc_count #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_pos_i),
      .preload_i(preload_i),
      .move_i   (move),
      .cnt_o    (live_cnt)
   );

   qenc_snap #(.CNT_W(CNT_W)) u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_idx_i(index_mode_i),
      .strobe_i  (snap_strobe_i),
      .idx_i     (sync_q[2]),
      .rd_i      (sense_rd_i),
      .cnt_i     (live_cnt),
      .snap_o    (snap_q),
      .flag_o    (index_flag_o)
   );

   assign snap_lo_o  = snap_q[BYTE_W-1:0];
   assign snap_mid_o = snap_q[2*BYTE_W-1:BYTE_W];
   assign snap_hi_o  = snap_q[3*BYTE_W-1:2*BYTE_W];
endmodule

// File: rtl/qenc_axis_chk.sv
module qenc_axis_chk #(
   parameter int CNT_W  = 24,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              snap_strobe_i,
   input logic              index_mode_i,
   input logic              load_pos_i,
   input logic [CNT_W-1:0]  preload_i,
   input logic              sense_rd_i,
   input logic [BYTE_W-1:0] snap_lo_o,
   input logic [BYTE_W-1:0] snap_mid_o,
   input logic [BYTE_W-1:0] snap_hi_o,
   input logic              index_flag_o,
   input logic [CNT_W-1:0]  live_cnt
);
   logic [CNT_W-1:0] cnt_prev;
   logic [CNT_W-1:0] delta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_prev <= '0;
      else        cnt_prev <= live_cnt;
   end
   assign delta = live_cnt - cnt_prev;

   // R2 R3 R4 R5
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load_pos_i) |-> (delta == '0 || delta == CNT_W'(1) || delta == '1));

   // R10
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_pos_i) |-> (live_cnt == $past(preload_i)));

   // R6 R7
   snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(index_mode_i) && !$past(snap_strobe_i))
      |-> ($stable(snap_lo_o) && $stable(snap_mid_o) && $stable(snap_hi_o)));

   // R8
   flag_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(index_flag_o) |-> $past(index_mode_i));

   // R9
   flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(index_flag_o) |-> $past(sense_rd_i));
endmodule

bind qenc_axis qenc_axis_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .snap_strobe_i(snap_strobe_i),
   .index_mode_i (index_mode_i),
   .load_pos_i   (load_pos_i),
   .preload_i    (preload_i),
   .sense_rd_i   (sense_rd_i),
   .snap_lo_o    (snap_lo_o),
   .snap_mid_o   (snap_mid_o),
   .snap_hi_o    (snap_hi_o),
   .index_flag_o (index_flag_o),
   .live_cnt     (live_cnt)
);

// File: tb/tb_qenc_axis.sv
module tb_qenc_axis;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        qa = 1'b0, qb = 1'b0, qi = 1'b0;
   logic        strobe = 1'b0, mode = 1'b0, load = 1'b0, rd = 1'b0;
   logic [23:0] pre = '0;
   logic [7:0]  lo, mid, hi;
   logic        flag;

   int checks = 0;
   int errors = 0;
   int ph = 0;

   always #2 clk = ~clk;

   qenc_axis dut (
      .clk(clk), .rst_n(rst_n), .quad_a_in(qa), .quad_b_in(qb), .index_in(qi),
      .snap_strobe_i(strobe), .index_mode_i(mode), .load_pos_i(load),
      .preload_i(pre), .sense_rd_i(rd), .snap_lo_o(lo), .snap_mid_o(mid),
      .snap_hi_o(hi), .index_flag_o(flag)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: raw samples pass through a two-entry queue, then a decode and counter
   logic [2:0]  m_q[$];
   logic [1:0]  m_pab;
   logic        m_pidx;
   logic [23:0] m_cnt, m_snap;
   logic        m_flag;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q = '{3'b000, 3'b000};
         m_pab = 2'b00; m_pidx = 1'b0;
         m_cnt = '0; m_snap = '0; m_flag = 1'b0;
      end else begin
         logic [2:0] s;
         logic       rise;
         int         mv;
         s = m_q[0];
         mv = 0;
         case ({m_pab, s[1:0]})
            4'b0010, 4'b1011, 4'b1101, 4'b0100: mv = 1;
            4'b1000, 4'b1110, 4'b0111, 4'b0001: mv = -1;
            default: mv = 0;
         endcase
         rise = s[2] && !m_pidx;
         if (mode ? rise : strobe) m_snap = m_cnt;
         if (mode && rise) m_flag = 1'b1;
         else if (rd)      m_flag = 1'b0;
         if (load) m_cnt = pre;
         else      m_cnt = m_cnt + 24'(mv);
         m_pab = s[1:0];
         m_pidx = s[2];
         void'(m_q.pop_front());
         m_q.push_back({qi, qa, qb});
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check("R6 R11 snapshot vs model", {8'h0, hi, mid, lo}, {8'h0, m_snap});
         check("R9 flag vs model", {31'h0, flag}, {31'h0, m_flag});
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [1:0] ab_of(input int p);
      case (p & 3)
         0: return 2'b00;
         1: return 2'b10;
         2: return 2'b11;
         default: return 2'b01;
      endcase
   endfunction

   task automatic move(input int n);
      int dir;
      dir = (n < 0) ? -1 : 1;
      for (int k = 0; k < (n < 0 ? -n : n); k++) begin
         @(negedge clk);
         ph = ph + dir;
         {qa, qb} = ab_of(ph);
         tick(2);
      end
      tick(2);
   endtask

   task automatic pulse_strobe();
      @(negedge clk); strobe = 1'b1;
      @(negedge clk); strobe = 1'b0;
      tick(1);
   endtask

   task automatic pulse_index();
      @(negedge clk); qi = 1'b1;
      tick(4);
      qi = 1'b0;
      tick(4);
   endtask

   task automatic do_load(input logic [23:0] v);
      @(negedge clk); pre = v; load = 1'b1;
      move(3);
      tick(12);
      load = 1'b0;
      tick(1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all) actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(1);
      check("R1 snapshot after reset", {8'h0, hi, mid, lo}, 32'h0);
      check("R1 flag after reset", {31'h0, flag}, 32'h0);

      move(8); pulse_strobe();
      check("R2 eight forward edges", {8'h0, hi, mid, lo}, 32'd8);
      move(-4); pulse_strobe();
      check("R3 four reverse edges", {8'h0, hi, mid, lo}, 32'd4);

      // R4: 00 -> 11 -> 00, both channels at once
      @(negedge clk); {qa, qb} = 2'b11; tick(4);
      {qa, qb} = 2'b00; tick(4);
      pulse_strobe();
      check("R4 double change ignored", {8'h0, hi, mid, lo}, 32'd4);

      move(2);
      check("R6 snapshot holds without capture", {8'h0, hi, mid, lo}, 32'd4);
      pulse_strobe();
      check("R6 R7 strobe capture", {8'h0, hi, mid, lo}, 32'd6);

      do_load(24'h000003); pulse_strobe();
      check("R10 load overrides steps", {8'h0, hi, mid, lo}, 32'd3);

      do_load(24'h000000); move(-1); pulse_strobe();
      check("R5 underflow wrap hi", {24'h0, hi}, 32'hff);
      check("R5 underflow wrap all", {8'h0, hi, mid, lo}, 32'hffffff);
      do_load(24'hffffff); move(1); pulse_strobe();
      check("R5 overflow wrap", {8'h0, hi, mid, lo}, 32'h0);

      move(5);
      mode = 1'b1;
      pulse_strobe();
      check("R8 strobe ignored in index mode", {8'h0, hi, mid, lo}, 32'h0);
      pulse_index();
      check("R8 index capture", {8'h0, hi, mid, lo}, 32'd5);
      check("R8 index sets flag", {31'h0, flag}, 32'h1);
      move(2);
      check("R9 flag sticky", {31'h0, flag}, 32'h1);
      @(negedge clk); rd = 1'b1;
      @(negedge clk); rd = 1'b0;
      check("R9 flag cleared by read", {31'h0, flag}, 32'h0);

      // R9 set wins: raw index rises, flag sets at the third edge, read held for that edge
      @(negedge clk); qi = 1'b1;
      tick(2); rd = 1'b1;
      tick(1); rd = 1'b0;
      check("R9 set wins over clear", {31'h0, flag}, 32'h1);
      check("R11 capture at third edge", {8'h0, hi, mid, lo}, 32'd7);
      tick(3); qi = 1'b0; tick(4);
      @(negedge clk); rd = 1'b1;
      @(negedge clk); rd = 1'b0;
      check("R9 flag cleared again", {31'h0, flag}, 32'h0);

      mode = 1'b0;
      move(1);
      pulse_index();
      check("R7 index ignored for snapshot", {8'h0, hi, mid, lo}, 32'd7);
      check("R7 index leaves flag clear", {31'h0, flag}, 32'h0);
      pulse_strobe();
      check("R7 strobe capture in timed mode", {8'h0, hi, mid, lo}, 32'd8);

      tick(4);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule